// File: doc/BRIEF.md
# First-Fault Vector Load Sequencer

This block carries out one predicated, contiguous vector load one element at a time. On a start command it latches a base address and a lane predicate. It then visits the active lanes from the lowest index to the highest. For each active lane it issues exactly one read on a single-element request/response memory port. Inactive lanes never reach memory.

A separate fault-mask register keeps one bit per lane and tells software how many lanes of the destination can be trusted.
- **Error on the first active lane:** the error is real. The block raises an exception flag and leaves both the destination and the fault mask as they were.
- **Error on any later active lane:** the error is swallowed. That lane and every lane above it are cleared in the fault mask, and no further reads go out.

This lets a loop whose exit depends on the data run ahead into memory that may not be mapped. Before each loop iteration, software restores the mask to all-true with a set-all command.

At the end of a load, the destination register is written in one step. Lanes that loaded hold their data, and every other lane holds zero. A one-cycle done pulse marks the point where the destination and the fault mask hold their final values.

The memory port uses two valid/ready channels, with one element per request.
- **Request channel:** `req_valid` and `req_addr` stay stable until `req_ready` is seen high at a clock edge.
- **Response channel:** a response is consumed only in a cycle where `resp_ready` is high. Memory may hold its response back for any number of cycles.

Top module: `ffld_seq`

## Requirements
- R1: After reset, `ffr` is all ones, `dst_data` is zero, and `busy`, `done` and `fault_exc` are low.
- R2: For each active lane `i`, in ascending order of `i`, one request is issued at address `base_addr + i*(ELEM_W/8)`, wrapping modulo 2^ADDR_W. A lane whose `pred` bit is 0 issues no request.
- R3: After a load without exception, lane `i` of `dst_data` (bits `[i*ELEM_W +: ELEM_W]`) holds the response data of that lane's read if it loaded, and holds zero if it was inactive or was not loaded.
- R4: An error response on the first active lane drives `fault_exc` high in the same cycle as `done`. In that case `ffr` and `dst_data` keep their previous values.
- R5: An error response on a later active lane `k` raises no exception. It clears `ffr` bits `k` and above, and leaves bits below `k` unchanged.
- R6: After a suppressed error, no further memory requests are issued for that load.
- R7: `ffr_setall` sets every `ffr` bit to one at the next clock edge when the block is idle. While `busy` is high it has no effect.
- R8: `done` is a single-cycle pulse after the load completes, and `busy` is high from the cycle after `start` until `done`. A start with an all-zero `pred` completes with no requests, zero data and `ffr` unchanged.
- R9: At most one request is outstanding at a time. `req_valid` and `req_addr` hold stable until accepted. `resp_ready` is never high while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; honoured only when idle |
| base_addr | input | ADDR_W | Byte address of lane 0 |
| pred | input | LANES | Lane predicate, 1 = active |
| ffr_setall | input | 1 | Set all fault-mask bits to one (idle only) |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse: load finished |
| fault_exc | output | 1 | With done: first active lane faulted |
| ffr | output | LANES | Fault-mask register, 1 = lane usable |
| dst_data | output | LANES*ELEM_W | Destination vector, lane i at bits [i*ELEM_W +: ELEM_W] |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | ADDR_W | Read byte address |
| resp_valid | input | 1 | Read response valid |
| resp_ready | output | 1 | Block accepts response |
| resp_data | input | ELEM_W | Read data |
| resp_err | input | 1 | Read faulted |

## Verification
The bench uses the default build of eight lanes with 16-bit elements and 16-bit addresses. Eight lanes are enough to place a fault on the first active lane, in the middle, and on the top lane, with predicates that are sparse, dense or empty. Two-byte elements with a random base reach address wraparound at the top of the 16-bit space. Random back-pressure on both channels exercises the handshakes while the fault-mask state carries over from one load to the next.

// File: rtl/ffld_pkg.sv
package ffld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ffld_lane_pick.sv
// Finds the lowest set bit of a lane vector.
module ffld_lane_pick #(
  parameter int LANES = 8,
  localparam int IW = $clog2(LANES)
) (
  input  logic [LANES-1:0] bits,
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ffld_tail_mask.sv
// keep[i] is 1 for every lane strictly below idx.
module ffld_tail_mask #(
  parameter int LANES = 8,
  localparam int IW = $clog2(LANES)
) (
  input  logic [IW-1:0]    idx,
  output logic [LANES-1:0] keep
);
  for (genvar g = 0; g < LANES; g++) begin : g_keep
    assign keep[g] = (IW'(g) < idx);
  end
endmodule

// File: rtl/ffld_seq.sv
module ffld_seq
  import ffld_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16,
  parameter int ADDR_W = 16,
  localparam int IW    = $clog2(LANES),
  localparam int DW    = LANES * ELEM_W,
  localparam int EB    = ELEM_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LANES-1:0]  pred,
  input  logic              ffr_setall,
  output logic              busy,
  output logic              done,
  output logic              fault_exc,
  output logic [LANES-1:0]  ffr,
  output logic [DW-1:0]     dst_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [ELEM_W-1:0] resp_data,
  input  logic              resp_err
);
  seq_state_t        state;
  logic [LANES-1:0]  pend_q;     // active lanes still to load
  logic [LANES-1:0]  pred_q;     // predicate of the current load
  logic [ADDR_W-1:0] base_q;
  logic              first_q;    // next lane is the first active one
  logic              exc_q;
  logic [DW-1:0]     dbuf;       // shadow destination
  logic              cur_found;
  logic [IW-1:0]     cur_idx;
  logic [LANES-1:0]  keep_mask;
  logic [LANES-1:0]  cur_onehot;
  logic              more_left;

  ffld_lane_pick #(.LANES(LANES)) u_pick (
    .bits (pend_q),
    .found(cur_found),
    .idx  (cur_idx)
  );

  ffld_tail_mask #(.LANES(LANES)) u_tail (
    .idx (cur_idx),
    .keep(keep_mask)
  );

  assign cur_onehot = LANES'(1) << cur_idx;
  assign more_left  = |(pend_q & ~cur_onehot);
  assign busy       = (state != ST_IDLE);
  assign req_valid  = (state == ST_ISSUE);
  assign resp_ready = (state == ST_WAIT);
  assign req_addr   = base_q + ADDR_W'(ADDR_W'(cur_idx) * ADDR_W'(EB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_q    <= '0;
      pred_q    <= '0;
      base_q    <= '0;
      first_q   <= 1'b0;
      exc_q     <= 1'b0;
      dbuf      <= '0;
      ffr       <= '1;
      dst_data  <= '0;
      done      <= 1'b0;
      fault_exc <= 1'b0;
    end else begin
      done      <= 1'b0;
      fault_exc <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ffr_setall) ffr <= '1;
          if (start) begin
            pend_q  <= pred;
            pred_q  <= pred;
            base_q  <= base_addr;
            first_q <= 1'b1;
            exc_q   <= 1'b0;
            dbuf    <= '0;
            state   <= (|pred) ? ST_ISSUE : ST_FIN;
          end
        end
        ST_ISSUE: begin
          if (req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (resp_valid) begin
            if (resp_err) begin
              if (first_q) exc_q <= 1'b1;
              else         ffr   <= ffr & keep_mask;
              state <= ST_FIN;
            end else begin
              dbuf[int'(cur_idx) * ELEM_W +: ELEM_W] <= resp_data;
              pend_q  <= pend_q & ~cur_onehot;
              first_q <= 1'b0;
              state   <= more_left ? ST_ISSUE : ST_FIN;
            end
          end
        end
        ST_FIN: begin
          done      <= 1'b1;
          fault_exc <= exc_q;
          if (!exc_q) dst_data <= dbuf;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: request held until accepted
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R9: never waiting for a response while requesting
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_ready && req_valid));
  // R2: only active lanes reach memory
  a_r2_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cur_found && pred_q[cur_idx]);
  // R8: done is a single pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: exception only reported with done
  a_r4_exc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fault_exc |-> done);
  // R5 / R7: while busy, fault-mask bits can only be cleared
  a_r7_no_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((ffr & ~$past(ffr)) == '0));
  // R4: exception leaves the destination untouched
  a_r4_dst_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fault_exc |-> $stable(dst_data));
endmodule

// File: tb/ffld_seq_bench.sv
module ffld_seq_bench;
  localparam int LANES  = 8;
  localparam int ELEM_W = 16;
  localparam int ADDR_W = 16;
  localparam int DW     = LANES * ELEM_W;
  localparam int EB     = ELEM_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [LANES-1:0] pred = '0;
  logic ffr_setall = 1'b0;
  logic busy, done, fault_exc;
  logic [LANES-1:0] ffr;
  logic [DW-1:0] dst_data;
  logic req_valid, req_ready, resp_valid, resp_ready, resp_err;
  logic [ADDR_W-1:0] req_addr;
  logic [ELEM_W-1:0] resp_data;

  always #4 clk = ~clk;

  ffld_seq #(.LANES(LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)) u_ffld_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .pred(pred),
    .ffr_setall(ffr_setall), .busy(busy), .done(done), .fault_exc(fault_exc),
    .ffr(ffr), .dst_data(dst_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_err(resp_err)
  );

  int checks = 0;
  int errors = 0;
  logic [LANES-1:0] faults = '0;
  logic [ADDR_W-1:0] cur_base = '0;
  logic [LANES-1:0] reqmask = '0;
  int last_lane = -1;
  bit order_bad = 1'b0;
  bit finished = 1'b0;

  function automatic logic [ELEM_W-1:0] mem_data(input logic [ADDR_W-1:0] a);
    return ELEM_W'(a ^ 16'h5A3C);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: decisions made at negedge, handshakes land on next posedge
  initial begin : mem_model
    bit pend = 0, fire_req = 0, fire_resp = 0;
    logic [ADDR_W-1:0] fire_addr = '0, paddr = '0;
    int plane = 0, dly = 0;
    req_ready = 0; resp_valid = 0; resp_data = '0; resp_err = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (fire_resp) pend = 0;
      if (fire_req) begin
        pend = 1;
        paddr = fire_addr;
        plane = int'(ADDR_W'(fire_addr - cur_base)) / EB;
        dly = $urandom % 3;
        if (plane < LANES) reqmask[plane] = 1'b1;
        if (plane <= last_lane) order_bad = 1'b1;
        last_lane = plane;
      end
      resp_valid = 0; resp_err = 0; resp_data = ELEM_W'($urandom);
      if (pend) begin
        if (dly == 0) begin
          resp_valid = 1;
          resp_data = mem_data(paddr);
          resp_err = (plane < LANES) ? faults[plane] : 1'b0;
        end else dly--;
      end
      req_ready = !pend && ($urandom % 4 != 0);
      fire_req = req_valid && req_ready;
      fire_addr = req_addr;
      fire_resp = resp_valid && resp_ready;
    end
  end

  task automatic run_op(input logic [ADDR_W-1:0] b, input logic [LANES-1:0] p,
                        input logic [LANES-1:0] f, input bit mid_setall);
    logic [DW-1:0] e_dst = dst_data;
    logic [LANES-1:0] e_ffr = ffr;
    logic [LANES-1:0] e_req = '0;
    logic [DW-1:0] nd = '0;
    bit e_exc = 0, first = 1, stop = 0;
    int to = 0;
    for (int i = 0; i < LANES; i++) begin
      if (p[i] && !stop) begin
        e_req[i] = 1'b1;
        if (f[i]) begin
          if (first) e_exc = 1;
          else for (int j = i; j < LANES; j++) e_ffr[j] = 1'b0;
          stop = 1;
        end else
          nd[i*ELEM_W +: ELEM_W] = mem_data(ADDR_W'(b + ADDR_W'(i * EB)));
        first = 0;
      end
    end
    if (!e_exc) e_dst = nd;
    faults = f; cur_base = b; reqmask = '0; last_lane = -1; order_bad = 0;
    start = 1; base_addr = b; pred = p;
    @(negedge clk);
    start = 0; ffr_setall = mid_setall;
    chk(busy == 1'b1, "R8 busy after start", DW'(busy), DW'(1));
    @(negedge clk);
    ffr_setall = 0;
    while (!done && to < 500) begin @(negedge clk); to++; end
    chk(done == 1'b1, "R8 done seen", DW'(done), DW'(1));
    chk(fault_exc == e_exc, "R4 exception flag", DW'(fault_exc), DW'(e_exc));
    chk(dst_data == e_dst, "R3 destination data", dst_data, e_dst);
    chk(ffr == e_ffr, "R5 fault mask", DW'(ffr), DW'(e_ffr));
    chk(reqmask == e_req, "R2/R6 lanes requested", DW'(reqmask), DW'(e_req));
    chk(!order_bad, "R2 ascending order", DW'(order_bad), DW'(0));
    @(negedge clk);
    chk(!done && !busy, "R8 done single pulse", DW'({done, busy}), DW'(0));
  endtask

  task automatic setall_idle();
    ffr_setall = 1;
    @(negedge clk);
    ffr_setall = 0;
    chk(ffr == '1, "R7 set-all when idle", DW'(ffr), DW'({LANES{1'b1}}));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ffr == '1 && dst_data == '0, "R1 reset state", {dst_data[DW-LANES-1:0], ffr},
        DW'({LANES{1'b1}}));
    chk(!busy && !done && !fault_exc, "R1 reset flags", DW'({busy, done, fault_exc}), DW'(0));
    // full predicate, no faults
    run_op(16'h1000, 8'hFF, 8'h00, 0);
    // empty predicate: no requests, zero data
    run_op(16'h2000, 8'h00, 8'hFF, 0);
    // fault on first active lane (lane 2): exception, state kept
    run_op(16'h3000, 8'hFF, 8'h00, 0);
    run_op(16'h3100, 8'hF4, 8'h04, 0);
    // suppressed fault on lane 5; fault on inactive lane 1 ignored
    run_op(16'h4000, 8'hFD, 8'h22, 0);
    // set-all while busy is ignored, mask stays cleared from lane 4
    run_op(16'h5000, 8'hFF, 8'h10, 1);
    setall_idle();
    // top-lane fault with address wraparound
    run_op(16'hFFF8, 8'h81, 8'h80, 0);
    setall_idle();
    for (int n = 0; n < 300; n++) begin
      logic [LANES-1:0] rp = LANES'($urandom);
      logic [LANES-1:0] rf = ($urandom % 3 == 0) ? '0 : LANES'($urandom & $urandom);
      if ($urandom % 3 == 0) setall_idle();
      run_op(ADDR_W'($urandom), rp, rf, ($urandom % 4 == 0));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule